// File: doc/BRIEF.md
# Serial Flash Page-Program Buffer

This block gathers one page of program data (128 bytes by default) and writes it to a serial NOR flash in a single page-program transfer on a one-lane SPI link. Software reaches it through a small word-wide register port. A configuration bit moves the shared buffer from its read-prefetch role into program-buffer mode. Software reads that bit back until it shows the new value, and the readback serves as the acknowledge. After that, software writes the page as packed 32-bit words to one data register. An internal word pointer advances on each write.

The start address is held in four byte-wide address registers. A mode bit selects 3-byte or 4-byte addressing. Writing the program command value sets a command bit. The sequencer then drops chip select and shifts out the opcode, the address bytes (most significant first) and every buffered byte. The command bit clears when chip select rises again. Polling the flash for completion is left to software.

Top module: `ppwb_top`

## Requirements
- R1: After reset, chip select (active low) is high, the serial clock is low, and both the command register (offset 0x00) and the configuration register (offset 0x08) read back 0.
- R2: Bit 0 of the configuration register (offset 0x08) selects program-buffer mode when 1 and read-prefetch mode when 0. Its readback shows the mode in effect. When idle, a write takes effect at once. A write made while a transfer runs takes effect only when that transfer ends.
- R3: Each word written to the data register (offset 0x04) holds four consecutive page bytes, little-endian: bits 7:0 carry the lowest byte and bits 31:24 the highest. Page bytes go out in ascending order.
- R4: Each accepted data write stores into the word slot given by the pointer and advances the pointer. The pointer wraps after 32 words, so a 33rd write replaces word 0.
- R5: The word pointer returns to 0 when program-buffer mode is entered and when a transfer ends.
- R6: Data writes are ignored while program-buffer mode is off or while a transfer runs. Page bytes not rewritten keep their previous values.
- R7: The address registers sit at offsets 0x10, 0x14, 0x18 (bits 7:0, 15:8, 23:16) and 0x24 (bits 31:24). Bit 4 of the address-mode register (offset 0x0C) selects 4 address bytes when set and 3 when clear. Address bytes are sent most significant first.
- R8: A transfer sends opcode 0x02, then the address bytes, then the 128 page bytes. Each byte goes out MSB first, SPI mode 0, one bit per two clock cycles. Chip select stays low for the whole frame, and the serial clock is low whenever chip select is high.
- R9: Writing a command word with bit 4 set (value 0x10) starts a transfer. Command bit 4 reads 1 from the following cycle until the cycle in which chip select returns high.
- R10: A program command issued while program-buffer mode is off is ignored. No frame is sent, and command bit 4 reads 0 on the next cycle.
- R11: A command word with bit 4 clear, or a program command issued while a transfer runs, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| spi_sck_o | output | 1 | Serial clock |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |

## Verification
The bench aims at the pointer edges: a 33rd word, a partial refill after the mode is re-entered, and writes made while the mode is off or a frame is running. A design with a wrong wrap, a missing pointer reset or an ungated write shows misplaced or corrupted page bytes in the captured frame. It issues the program command with the mode off and with a command value whose bit 4 is clear. A design that ignored the gating would send an unexpected frame or leave the command bit set. It switches the mode off during a frame, and a design that applied the change at once would show the new value in the readback too early. It also sends frames in both address widths, which catches wrong address-byte order or an extra or missing address byte.

// File: rtl/ppwb_pkg.sv
package ppwb_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_CMD  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_DATA = 8'h04;
  localparam logic [REG_AW-1:0] OFS_CFG  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_AMOD = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_AB0  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_AB1  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_AB2  = 8'h18;
  localparam logic [REG_AW-1:0] OFS_AB3  = 8'h24;

  localparam int unsigned CMD_PROG_BIT = 4;
  localparam int unsigned AMOD_4B_BIT  = 4;
  localparam logic [7:0]  OP_PAGE_PROG = 8'h02;

  function automatic logic [REG_AW-1:0] addr_byte_ofs(input int unsigned idx);
    case (idx)
      0:       return OFS_AB0;
      1:       return OFS_AB1;
      2:       return OFS_AB2;
      default: return OFS_AB3;
    endcase
  endfunction
endpackage

// File: rtl/ppwb_regs.sv
module ppwb_regs
  import ppwb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              seq_done_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              buf_mode_o,
  output logic              addr4_o,
  output logic [3:0][7:0]   start_addr_o,
  output logic              start_o,
  output logic              busy_o,
  output logic              data_we_o,
  output logic              ptr_clr_o
);
  logic            mode_req_q, buf_mode_q, addr4_q, busy_q;
  logic            mode_req_d, buf_mode_d;
  logic [3:0][7:0] adr_q;
  logic            wr_cmd, wr_cfg, wr_amod, wr_data;

  assign wr_cmd  = we_i && (addr_i == OFS_CMD);
  assign wr_cfg  = we_i && (addr_i == OFS_CFG);
  assign wr_amod = we_i && (addr_i == OFS_AMOD);
  assign wr_data = we_i && (addr_i == OFS_DATA);

  assign mode_req_d = wr_cfg ? wdata_i[0] : mode_req_q;
  // mode change is held off while the buffer is being drained
  assign buf_mode_d = (busy_q && !seq_done_i) ? buf_mode_q : mode_req_d;

  assign start_o   = wr_cmd && wdata_i[CMD_PROG_BIT] && buf_mode_q && !busy_q;
  assign data_we_o = wr_data && buf_mode_q && !busy_q;
  assign ptr_clr_o = (buf_mode_d && !buf_mode_q) || seq_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_req_q <= 1'b0;
      buf_mode_q <= 1'b0;
      addr4_q    <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      mode_req_q <= mode_req_d;
      buf_mode_q <= buf_mode_d;
      if (wr_amod) addr4_q <= wdata_i[AMOD_4B_BIT];
      if (start_o) busy_q <= 1'b1;
      else if (seq_done_i) busy_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_adr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) adr_q[g] <= '0;
      else if (we_i && (addr_i == addr_byte_ofs(g))) adr_q[g] <= wdata_i[7:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CMD:  rdata_o[CMD_PROG_BIT] = busy_q;
      OFS_CFG:  rdata_o[0] = buf_mode_q;
      OFS_AMOD: rdata_o[AMOD_4B_BIT] = addr4_q;
      OFS_AB0:  rdata_o[7:0] = adr_q[0];
      OFS_AB1:  rdata_o[7:0] = adr_q[1];
      OFS_AB2:  rdata_o[7:0] = adr_q[2];
      OFS_AB3:  rdata_o[7:0] = adr_q[3];
      default:  rdata_o = '0;
    endcase
  end

  assign buf_mode_o   = buf_mode_q;
  assign addr4_o      = addr4_q;
  assign start_addr_o = adr_q;
  assign busy_o       = busy_q;
endmodule

// File: rtl/ppwb_buf.sv
module ppwb_buf #(
  parameter int unsigned PAGE_BYTES = 128,
  parameter int unsigned WORD_W     = 32,
  localparam int unsigned WORD_BYTES = WORD_W / 8,
  localparam int unsigned NUM_WORDS  = PAGE_BYTES / WORD_BYTES,
  localparam int unsigned PTR_W      = $clog2(NUM_WORDS),
  localparam int unsigned LANE_W     = $clog2(WORD_BYTES),
  localparam int unsigned BIDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ptr_clr_i,
  input  logic [BIDX_W-1:0] rd_idx_i,
  output logic [7:0]        rd_byte_o
);
  logic [WORD_W-1:0] mem_q [NUM_WORDS];
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  rd_word;
  logic [LANE_W-1:0] rd_lane;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (ptr_clr_i) ptr_q <= '0;
    else if (wr_en_i)   ptr_q <= ptr_q + 1'b1;  // wraps at NUM_WORDS
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !ptr_clr_i) mem_q[ptr_q] <= wdata_i;
  end

  assign rd_word   = rd_idx_i[BIDX_W-1:LANE_W];
  assign rd_lane   = rd_idx_i[LANE_W-1:0];
  // little-endian lanes: lowest byte address in bits 7:0
  assign rd_byte_o = mem_q[rd_word][8*rd_lane +: 8];
endmodule

// File: rtl/ppwb_seq.sv
module ppwb_seq
  import ppwb_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 128,
  localparam int unsigned BIDX_W = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W  = $clog2(PAGE_BYTES + 5) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              addr4_i,
  input  logic [3:0][7:0]   start_addr_i,
  input  logic [7:0]        buf_byte_i,
  output logic [BIDX_W-1:0] buf_idx_o,
  output logic              done_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o
);
  typedef enum logic {SEQ_IDLE, SEQ_SHIFT} seq_state_e;

  seq_state_e       state_q;
  logic             phase_q, a4_q;
  logic [2:0]       bit_q;
  logic [CNT_W-1:0] byte_q;
  logic [3:0][7:0]  adr_q;
  logic [7:0]       shreg_q, src_byte;
  logic [CNT_W-1:0] n_addr, nxt, last_idx, sel, data_off;
  logic             last_byte, byte_end;

  assign n_addr    = a4_q ? CNT_W'(4) : CNT_W'(3);
  assign nxt       = byte_q + CNT_W'(1);
  assign last_idx  = n_addr + CNT_W'(PAGE_BYTES);
  assign last_byte = (byte_q == last_idx);
  assign sel       = n_addr - nxt;
  assign data_off  = byte_q - n_addr;
  assign buf_idx_o = data_off[BIDX_W-1:0];
  assign byte_end  = (state_q == SEQ_SHIFT) && phase_q && (bit_q == 3'd0);
  assign done_o    = byte_end && last_byte;

  always_comb begin
    if (nxt <= n_addr) src_byte = adr_q[sel[1:0]];  // address MSB first
    else               src_byte = buf_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      phase_q <= 1'b0;
      a4_q    <= 1'b0;
      bit_q   <= 3'd7;
      byte_q  <= '0;
      adr_q   <= '0;
      shreg_q <= '0;
    end else if (state_q == SEQ_IDLE) begin
      if (start_i) begin
        state_q <= SEQ_SHIFT;
        phase_q <= 1'b0;
        bit_q   <= 3'd7;
        byte_q  <= '0;
        a4_q    <= addr4_i;
        adr_q   <= start_addr_i;
        shreg_q <= OP_PAGE_PROG;
      end
    end else begin
      phase_q <= !phase_q;
      if (phase_q) begin
        if (bit_q != 3'd0) begin
          bit_q   <= bit_q - 3'd1;
          shreg_q <= {shreg_q[6:0], 1'b0};
        end else if (last_byte) begin
          state_q <= SEQ_IDLE;
        end else begin
          bit_q   <= 3'd7;
          byte_q  <= nxt;
          shreg_q <= src_byte;
        end
      end
    end
  end

  assign sck_o  = phase_q;
  assign cs_no  = (state_q == SEQ_IDLE);
  assign mosi_o = shreg_q[7];
endmodule

// File: rtl/ppwb_top.sv
module ppwb_top
  import ppwb_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 128,
  localparam int unsigned BIDX_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              spi_sck_o,
  output logic              spi_cs_no,
  output logic              spi_mosi_o
);
  logic              buf_mode, addr4, start, busy, data_we, ptr_clr, seq_done;
  logic [3:0][7:0]   start_addr;
  logic [BIDX_W-1:0] buf_idx;
  logic [7:0]        buf_byte;

  ppwb_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .seq_done_i   (seq_done),
    .rdata_o      (reg_rdata_o),
    .buf_mode_o   (buf_mode),
    .addr4_o      (addr4),
    .start_addr_o (start_addr),
    .start_o      (start),
    .busy_o       (busy),
    .data_we_o    (data_we),
    .ptr_clr_o    (ptr_clr)
  );

  ppwb_buf #(.PAGE_BYTES(PAGE_BYTES), .WORD_W(REG_DW)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (data_we),
    .wdata_i   (reg_wdata_i),
    .ptr_clr_i (ptr_clr),
    .rd_idx_i  (buf_idx),
    .rd_byte_o (buf_byte)
  );

  ppwb_seq #(.PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .addr4_i      (addr4),
    .start_addr_i (start_addr),
    .buf_byte_i   (buf_byte),
    .buf_idx_o    (buf_idx),
    .done_o       (seq_done),
    .sck_o        (spi_sck_o),
    .cs_no        (spi_cs_no),
    .mosi_o       (spi_mosi_o)
  );
endmodule

// File: rtl/ppwb_chk.sv
module ppwb_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic spi_cs_no,
  input logic spi_sck_o,
  input logic busy,
  input logic buf_mode
);
  // R8
  cs_idle_sck_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);
  // R8
  sck_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spi_cs_no && !$past(spi_cs_no)) |-> (spi_sck_o != $past(spi_sck_o)));
  // R9
  frame_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_cs_no |-> busy);
  // R10
  start_needs_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_cs_no) |-> buf_mode);
  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(buf_mode));
endmodule

bind ppwb_top ppwb_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .spi_cs_no (spi_cs_no),
  .spi_sck_o (spi_sck_o),
  .busy      (busy),
  .buf_mode  (buf_mode)
);

// File: tb/ppwb_top_tb_top.sv
module ppwb_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, cs_n, mosi;

  always #5 clk = ~clk;

  ppwb_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  int exp_len = 0, frames = 0, nbits = 0, nbytes = 0;
  logic [7:0] sh = '0;

  always @(negedge cs_n) if (rst_n) begin
    frames++; nbits = 0; nbytes = 0;
  end

  always @(posedge sck) if (rst_n && !cs_n) begin
    sh = {sh[6:0], mosi};
    nbits++;
    if (nbits % 8 == 0) begin
      nbytes++;
      if (exp_q.size() == 0) check(0, "R8 extra byte", sh, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(sh == e, "R3/R7/R8 frame byte", sh, e);
      end
    end
  end

  always @(posedge cs_n) if (rst_n) begin
    check(nbits == 8 * exp_len, "R8 frame length bits", nbits, 8 * exp_len);
  end

  // bench model of the buffer
  logic [31:0] m_mem [32];
  int  m_ptr = 0;
  bit  m_mode = 0, m_busy = 0;

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic push_word(input logic [31:0] w);
    reg_write(8'h04, w);
    if (m_mode && !m_busy) begin
      m_mem[m_ptr] = w;
      m_ptr = (m_ptr + 1) % 32;
    end
  endtask

  task automatic set_mode(input bit m);
    reg_write(8'h08, {31'b0, m});
    if (m && !m_mode) m_ptr = 0;
    m_mode = m;
  endtask

  task automatic set_addr(input logic [31:0] a, input bit four);
    reg_write(8'h10, {24'b0, a[7:0]});
    reg_write(8'h14, {24'b0, a[15:8]});
    reg_write(8'h18, {24'b0, a[23:16]});
    reg_write(8'h24, {24'b0, a[31:24]});
    reg_write(8'h0C, {27'b0, four, 4'b0});
  endtask

  task automatic start_page(input logic [31:0] a, input bit four);
    logic [31:0] r;
    exp_q.push_back(8'h02);
    if (four) exp_q.push_back(a[31:24]);
    exp_q.push_back(a[23:16]);
    exp_q.push_back(a[15:8]);
    exp_q.push_back(a[7:0]);
    for (int i = 0; i < 128; i++) exp_q.push_back(m_mem[i / 4][8 * (i % 4) +: 8]);
    exp_len = four ? 133 : 132;
    reg_write(8'h00, 32'h10);
    m_busy = 1;
    reg_read(8'h00, r);
    check(r[4] == 1'b1, "R9 busy after start", r[4], 1);
    check(cs_n == 1'b0, "R9 cs low after start", cs_n, 0);
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    int bad = 0;
    for (int i = 0; i < 4000; i++) begin
      reg_read(8'h00, r);
      if (r[4] != !cs_n) bad++;
      if (!r[4]) break;
    end
    check(bad == 0 && r[4] == 1'b0, "R9 busy tracks cs", bad, 0);
    check(exp_q.size() == 0, "R8 all bytes sent", exp_q.size(), 0);
    m_busy = 0;
    m_ptr = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(8'h00, r); check(r == 0, "R1 cmd reset", r, 0);
    reg_read(8'h08, r); check(r == 0, "R1 cfg reset", r, 0);
    check(cs_n == 1'b1, "R1 cs idle", cs_n, 1);
    check(sck == 1'b0, "R1 sck idle", sck, 0);

    // R10 program command with mode off
    f0 = frames;
    reg_write(8'h00, 32'h10);
    reg_read(8'h00, r); check(r[4] == 1'b0, "R10 cmd bit clears", r[4], 0);
    repeat (20) @(negedge clk);
    check(frames == f0, "R10 no frame", frames, f0);

    // R2 enter buffer mode
    set_mode(1);
    reg_read(8'h08, r); check(r[0] == 1'b1, "R2 mode readback", r[0], 1);

    // R11 command without bit 4
    f0 = frames;
    reg_write(8'h00, 32'h01);
    reg_read(8'h00, r); check(r[4] == 1'b0, "R11 bit4 clear cmd", r[4], 0);
    repeat (10) @(negedge clk);
    check(frames == f0, "R11 no frame", frames, f0);

    // R3 R7 R8: full page, 3-byte address
    for (int i = 0; i < 32; i++) push_word({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)} ^ 32'h5A00_C300);
    set_addr(32'hA5123456, 1'b0);
    start_page(32'hA5123456, 1'b0);
    wait_idle();
    check(frames == f0 + 1, "R8 one frame", frames, f0 + 1);

    // R4 wrap: 33 words, 4-byte address (R7)
    for (int i = 0; i < 33; i++) push_word(32'h1000_0000 + 32'(i) * 32'h0101_0101);
    set_addr(32'hC0FFEE11, 1'b1);
    start_page(32'hC0FFEE11, 1'b1);
    wait_idle();

    // R5 pointer reset on mode entry, R6 ignored writes while off
    push_word(32'hDEAD_0001);
    push_word(32'hDEAD_0002);
    push_word(32'hDEAD_0003);
    set_mode(0);
    reg_read(8'h08, r); check(r[0] == 1'b0, "R2 mode off readback", r[0], 0);
    for (int i = 0; i < 4; i++) push_word(32'hBAD0_0000 + 32'(i));
    set_mode(1);
    for (int i = 0; i < 8; i++) push_word(32'h7700_0000 + 32'(i));
    start_page(32'hC0FFEE11, 1'b1);

    // R2 deferred mode change, R6 data ignored while busy, R11 cmd while busy
    reg_write(8'h08, 32'h0);
    reg_read(8'h08, r); check(r[0] == 1'b1, "R2 mode held while busy", r[0], 1);
    push_word(32'hFFFF_FFFF);
    f0 = frames;
    reg_write(8'h00, 32'h10);
    wait_idle();
    check(frames == f0, "R11 no restart while busy", frames, f0);
    m_mode = 0;
    reg_read(8'h08, r); check(r[0] == 1'b0, "R2 mode applied after frame", r[0], 0);

    // R5 pointer reset at frame end: re-enter, write 2 words, resend
    set_mode(1);
    push_word(32'h0BAD_F00D);
    push_word(32'h1234_5678);
    set_addr(32'h00ABCDEF, 1'b0);
    start_page(32'h00ABCDEF, 1'b0);
    wait_idle();
    check(cs_n == 1'b1 && sck == 1'b0, "R8 idle after frame", {cs_n, sck}, 2'b10);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule